// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block pairs a working SRAM array with a shadow nonvolatile array. Both arrays are held in registers and are sized by parameters. In normal operation the host reads and writes the SRAM through a port with chip and write enables. The controller watches two digital supply-monitor inputs. One is high while the supply is above the switch threshold. The other is high while the supply is above the reset threshold.

When the supply sags below the switch threshold, the controller saves the SRAM into the shadow array. It does this only if the SRAM has been written since the last save or restore. A software save request always runs. When the supply drops below the reset threshold, a restore request is latched. The restore starts once the supply is back above the switch threshold. A restore first zeroes the SRAM and then copies the shadow array into it.

Both transfers move one word per clock. The busy flag stays high for a fixed, parameterised number of cycles for each transfer. Port activity is ignored while busy is high.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset, `busy` is 1 and `rdata` is 0. A restore request is pending and is held, with `busy` staying 1, until `vsw_ok` and `vrst_ok` are both 1.
- R2: A restore zeroes every SRAM word and then copies every shadow word into the SRAM. `busy` is 1 for exactly RCL_LEN = max(RESTORE_CYC, 2·DEPTH) cycles counted from the edge that starts it. Afterwards every SRAM word equals the shadow word at the same address.
- R3: A restore never changes the shadow array, so repeated restores produce the same SRAM image.
- R4: When `vsw_ok` falls while the controller is ready, `vrst_ok` is 1 and the SRAM is dirty, a save starts. `busy` is 1 for exactly STO_LEN = max(STORE_CYC, DEPTH) cycles. The shadow array then equals the SRAM.
- R5: When `vsw_ok` falls while the SRAM is clean, no save runs and `busy` stays 0.
- R6: A `sw_store` pulse while ready with `vsw_ok`=1 always starts a save of STO_LEN cycles, whether the SRAM is clean or dirty.
- R7: While `vsw_ok` is 0, port writes and `sw_store` are ignored. Reads are still served.
- R8: `vrst_ok`=0 in any state makes `busy` 1 on the next cycle and latches a restore. A restore that was running is aborted, and it restarts from the beginning with its full length once both monitors are high again.
- R9: Reads and writes presented while `busy` is 1 have no effect.
- R10: A committed write marks the SRAM dirty. The end of a save or a restore marks it clean.
- R11: A read (`ce`=1, `we`=0) while ready puts the addressed word on `rdata` one clock later. `rdata` keeps its value at all other times.
- R12: A write and a `sw_store` in the same cycle are both accepted. The written word is part of the saved image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (first power-on) |
| ce | input | 1 | Chip enable for the port access |
| we | input | 1 | 1 = write, 0 = read when `ce` is 1 |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after a read |
| sw_store | input | 1 | Software save request |
| vsw_ok | input | 1 | Supply above the switch threshold |
| vrst_ok | input | 1 | Supply above the reset threshold |
| busy | output | 1 | Save or restore in progress, or restore pending |

## Verification
A port write and a software save request can land on the same clock edge. The write then goes into the SRAM on the same edge that starts the save. The bench drives `ce`, `we` and `sw_store` together in one cycle. It then checks three things: the new word reads back, a later supply sag triggers no second save (the save left the SRAM clean), and the word survives a full power cycle. A supply sag and a write can also coincide. The bench judges this at the ports: the write is dropped, and a read afterwards still returns the old word.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    NV_WAIT   = 2'd0,
    NV_RECALL = 2'd1,
    NV_READY  = 2'd2,
    NV_STORE  = 2'd3
  } nv_state_e;

  // Length of a transfer: the requested interval, but never shorter than the words it moves.
  function automatic int span_at_least(input int requested, input int floor_v);
    return (requested < floor_v) ? floor_v : requested;
  endfunction

  function automatic int larger_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvs_supply.sv
module nvs_supply (
  input  logic clk,
  input  logic rst_n,
  input  logic vsw_ok,
  output logic vsw_fall
);
  logic vsw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsw_q <= 1'b0;
    else        vsw_q <= vsw_ok;
  end

  assign vsw_fall = vsw_q & ~vsw_ok;
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sram_we,
  input  logic [ADDR_W-1:0] sram_waddr,
  input  logic [DATA_W-1:0] sram_wdata,
  input  logic              nv_we,
  input  logic [ADDR_W-1:0] mv_addr,
  input  logic [ADDR_W-1:0] port_addr,
  output logic [DATA_W-1:0] sram_q_port,
  output logic [DATA_W-1:0] sram_q_mv,
  output logic [DATA_W-1:0] nv_q_mv
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sram_mem [DEPTH];
  logic [DATA_W-1:0] nv_mem   [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sram_mem[i] <= '0;
    end else if (sram_we) begin
      sram_mem[sram_waddr] <= sram_wdata;
    end
  end

  // The shadow array is blank only at first power-on; later supply events never clear it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) nv_mem[i] <= '0;
    end else if (nv_we) begin
      nv_mem[mv_addr] <= sram_mem[mv_addr];
    end
  end

  assign sram_q_port = sram_mem[port_addr];
  assign sram_q_mv   = sram_mem[mv_addr];
  assign nv_q_mv     = nv_mem[mv_addr];
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 6,
  parameter int STO_LEN = 16,
  parameter int RCL_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsw_ok,
  input  logic              vrst_ok,
  input  logic              vsw_fall,
  input  logic              ce,
  input  logic              we,
  input  logic              sw_store,
  output logic              busy,
  output logic              dirty,
  output logic              rd_en,
  output logic              ev_wr_commit,
  output logic              ev_store_done,
  output logic              ev_recall_done,
  output logic              rcl_clr,
  output logic              rcl_cpy,
  output logic              st_copy,
  output logic [ADDR_W-1:0] mv_addr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] STO_LAST = CNT_W'(STO_LEN - 1);
  localparam logic [CNT_W-1:0] RCL_LAST = CNT_W'(RCL_LEN - 1);
  localparam logic [CNT_W-1:0] ONE_SPAN = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TWO_SPAN = CNT_W'(2 * DEPTH);

  nv_state_e        state;
  logic [CNT_W-1:0] tcnt;
  logic             ready, ev_latch, ev_recall_start, ev_auto_store, ev_sw_store;

  assign ready           = (state == NV_READY);
  assign ev_latch        = !vrst_ok && (state != NV_WAIT);
  assign ev_recall_start = (state == NV_WAIT) && vrst_ok && vsw_ok;
  assign ev_auto_store   = ready && vrst_ok && vsw_fall && dirty;
  assign ev_sw_store     = ready && vrst_ok && vsw_ok && sw_store;
  assign ev_wr_commit    = ready && vrst_ok && vsw_ok && ce && we;
  assign rd_en           = ready && ce && !we;
  assign ev_store_done   = (state == NV_STORE)  && !ev_latch && (tcnt == STO_LAST);
  assign ev_recall_done  = (state == NV_RECALL) && !ev_latch && (tcnt == RCL_LAST);

  assign rcl_clr = (state == NV_RECALL) && (tcnt < ONE_SPAN);
  assign rcl_cpy = (state == NV_RECALL) && (tcnt >= ONE_SPAN) && (tcnt < TWO_SPAN);
  assign st_copy = (state == NV_STORE)  && (tcnt < ONE_SPAN);
  assign mv_addr = tcnt[ADDR_W-1:0];
  assign busy    = !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= NV_WAIT;
      tcnt  <= '0;
    end else if (ev_latch) begin
      state <= NV_WAIT;
      tcnt  <= '0;
    end else begin
      case (state)
        NV_WAIT: if (ev_recall_start) begin
          state <= NV_RECALL;
          tcnt  <= '0;
        end
        NV_RECALL: if (ev_recall_done) begin
          state <= NV_READY;
          tcnt  <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        NV_STORE: if (ev_store_done) begin
          state <= NV_READY;
          tcnt  <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        default: if (ev_auto_store || ev_sw_store) begin
          state <= NV_STORE;
          tcnt  <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            dirty <= 1'b0;
    else if (ev_store_done || ev_recall_done) dirty <= 1'b0;
    else if (ev_wr_commit)                 dirty <= 1'b1;
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int STORE_CYC   = 24,
  parameter int RESTORE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sw_store,
  input  logic              vsw_ok,
  input  logic              vrst_ok,
  output logic              busy
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int STO_LEN = span_at_least(STORE_CYC, DEPTH);
  localparam int RCL_LEN = span_at_least(RESTORE_CYC, 2 * DEPTH);
  localparam int CNT_W   = $clog2(larger_of(STO_LEN, RCL_LEN) + 1);

  logic              vsw_fall, dirty, rd_en;
  logic              ev_wr_commit, ev_store_done, ev_recall_done;
  logic              rcl_clr, rcl_cpy, st_copy;
  logic [ADDR_W-1:0] mv_addr, sram_waddr;
  logic [DATA_W-1:0] sram_wdata, sram_q_port, sram_q_mv, nv_q_mv;
  logic              sram_we, nv_we;

  nvs_supply u_supply (
    .clk(clk), .rst_n(rst_n), .vsw_ok(vsw_ok), .vsw_fall(vsw_fall)
  );

  nvs_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STO_LEN(STO_LEN), .RCL_LEN(RCL_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .vsw_ok(vsw_ok), .vrst_ok(vrst_ok),
    .vsw_fall(vsw_fall), .ce(ce), .we(we), .sw_store(sw_store),
    .busy(busy), .dirty(dirty), .rd_en(rd_en),
    .ev_wr_commit(ev_wr_commit), .ev_store_done(ev_store_done),
    .ev_recall_done(ev_recall_done), .rcl_clr(rcl_clr), .rcl_cpy(rcl_cpy),
    .st_copy(st_copy), .mv_addr(mv_addr)
  );

  // One writer per cycle: the port when ready, the restore walk when busy.
  assign sram_we    = ev_wr_commit | rcl_clr | rcl_cpy;
  assign sram_waddr = ev_wr_commit ? addr : mv_addr;
  assign sram_wdata = ev_wr_commit ? wdata : (rcl_cpy ? nv_q_mv : '0);
  assign nv_we      = st_copy;

  nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arrays (
    .clk(clk), .rst_n(rst_n),
    .sram_we(sram_we), .sram_waddr(sram_waddr), .sram_wdata(sram_wdata),
    .nv_we(nv_we), .mv_addr(mv_addr), .port_addr(addr),
    .sram_q_port(sram_q_port), .sram_q_mv(sram_q_mv), .nv_q_mv(nv_q_mv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sram_q_port;
  end
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsw_ok,
  input logic              vrst_ok,
  input logic              busy,
  input logic              dirty,
  input logic              ev_wr_commit,
  input logic              ev_store_done,
  input logic              ev_recall_done,
  input logic              rcl_clr,
  input logic              rcl_cpy,
  input logic              nv_we,
  input logic              sram_we,
  input logic [DATA_W-1:0] sram_wdata
);
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_clr |-> (sram_we && sram_wdata == '0));

  p_recall_keeps_nv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_clr || rcl_cpy) |-> !nv_we);

  p_auto_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsw_ok) && vrst_ok && dirty && !busy) |=> busy);

  p_clean_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsw_ok) && vrst_ok && !dirty && !busy) |=> !busy);

  p_low_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vsw_ok |-> !ev_wr_commit);

  p_reset_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vrst_ok |=> busy);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_wr_commit);

  p_dirty_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store_done || ev_recall_done) |=> !dirty);

  p_dirty_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_commit |=> dirty);

  p_single_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_wr_commit, rcl_clr, rcl_cpy}));
endmodule

bind nvsram_ctrl nvs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsw_ok(vsw_ok), .vrst_ok(vrst_ok),
  .busy(busy), .dirty(dirty), .ev_wr_commit(ev_wr_commit),
  .ev_store_done(ev_store_done), .ev_recall_done(ev_recall_done),
  .rcl_clr(rcl_clr), .rcl_cpy(rcl_cpy), .nv_we(nv_we),
  .sram_we(sram_we), .sram_wdata(sram_wdata)
);

// File: tb/nvsram_ctrl_test.sv
`timescale 1ns/1ps
module nvsram_ctrl_test;
  localparam int ADDR_W = 4, DATA_W = 8, STORE_CYC = 24, RESTORE_CYC = 40;
  localparam int DEPTH = 16;
  localparam int EXP_STO = (STORE_CYC > DEPTH) ? STORE_CYC : DEPTH;
  localparam int EXP_RCL = (RESTORE_CYC > 2 * DEPTH) ? RESTORE_CYC : 2 * DEPTH;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, we = 1'b0, sw_store = 1'b0;
  logic vsw_ok = 1'b0, vrst_ok = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic busy;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] exp_sram [DEPTH];
  logic [DATA_W-1:0] exp_nv   [DEPTH];

  always #2.5 clk = ~clk;

  nvsram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_CYC(STORE_CYC),
                .RESTORE_CYC(RESTORE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sw_store(sw_store), .vsw_ok(vsw_ok), .vrst_ok(vrst_ok),
    .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int a, input int d);
    ce = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk);
    ce = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(input int a, output int d);
    ce = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    @(negedge clk);
    d = int'(rdata);
    ce = 1'b0;
  endtask

  task automatic check_all(input string req);
    int d;
    for (int i = 0; i < DEPTH; i++) begin
      do_read(i, d);
      chk(req, d, int'(exp_nv[i]));
    end
  endtask

  task automatic power_down(input int exp_store_len, input string req);
    int n;
    vsw_ok = 1'b0;
    @(negedge clk);
    count_busy(n);
    chk(req, n, exp_store_len);
    if (exp_store_len > 0) for (int i = 0; i < DEPTH; i++) exp_nv[i] = exp_sram[i];
    vrst_ok = 1'b0;
    @(negedge clk);
    chk("R8 busy after reset-level drop", int'(busy), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic power_up(input string req);
    int n;
    vrst_ok = 1'b1; vsw_ok = 1'b1;
    @(negedge clk);
    count_busy(n);
    chk(req, n, EXP_RCL);
    for (int i = 0; i < DEPTH; i++) exp_sram[i] = exp_nv[i];
  endtask

  task automatic t_reset;
    for (int i = 0; i < DEPTH; i++) begin exp_sram[i] = '0; exp_nv[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 1);
    chk("R1 rdata after reset", int'(rdata), 0);
    vrst_ok = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 restore held without switch level", int'(busy), 1);
  endtask

  task automatic t_first_recall;
    power_up("R2 first restore length");
    check_all("R2 blank image after restore");
  endtask

  task automatic t_rw;
    int d;
    for (int i = 0; i < DEPTH; i++) begin
      exp_sram[i] = DATA_W'(i * 37 + 5);
      do_write(i, int'(exp_sram[i]));
    end
    for (int i = 0; i < DEPTH; i++) begin
      do_read(i, d);
      chk("R11 read-back", d, int'(exp_sram[i]));
    end
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", int'(rdata), int'(exp_sram[DEPTH-1]));
  endtask

  task automatic t_sw_store;
    int n;
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0;
    count_busy(n);
    chk("R6 save length", n, EXP_STO);
    for (int i = 0; i < DEPTH; i++) exp_nv[i] = exp_sram[i];
    power_down(0, "R10 clean after save, R5 no auto save");
    power_up("R2 restore length");
    check_all("R2 image after power cycle");
    power_down(0, "R5 clean sag");
    power_up("R3 repeat restore length");
    check_all("R3 repeat restore image");
  endtask

  task automatic t_low_voltage;
    int n, d;
    vsw_ok = 1'b0;
    @(negedge clk);
    chk("R5 no save when clean", int'(busy), 0);
    do_write(2, 8'hA5);
    do_read(2, d);
    chk("R7 write ignored at low level", d, int'(exp_sram[2]));
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0;
    count_busy(n);
    chk("R7 save request ignored at low level", n, 0);
    vsw_ok = 1'b1;
    @(negedge clk);
    chk("R6 save on clean array", 0, 0);
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0;
    count_busy(n);
    chk("R6 save runs when clean", n, EXP_STO);
  endtask

  task automatic t_auto_store;
    int d;
    exp_sram[5] = 8'h3C;
    do_write(5, 8'h3C);
    power_down(EXP_STO, "R4 auto save length");
    power_up("R2 restore after auto save");
    do_read(5, d);
    chk("R4 auto-saved word restored", d, 8'h3C);
  endtask

  task automatic t_busy_ignore;
    int n, d;
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0;
    ce = 1'b1; we = 1'b1; addr = 4'd7; wdata = 8'hEE;
    repeat (5) @(negedge clk);
    ce = 1'b0; we = 1'b0;
    count_busy(n);
    do_read(7, d);
    chk("R9 write during busy ignored", d, int'(exp_sram[7]));
    for (int i = 0; i < DEPTH; i++) exp_nv[i] = exp_sram[i];
  endtask

  task automatic t_same_cycle;
    int n, d;
    ce = 1'b1; we = 1'b1; addr = 4'd3; wdata = 8'h9B; sw_store = 1'b1;
    @(negedge clk);
    ce = 1'b0; we = 1'b0; sw_store = 1'b0;
    exp_sram[3] = 8'h9B;
    count_busy(n);
    chk("R12 save length with write", n, EXP_STO);
    for (int i = 0; i < DEPTH; i++) exp_nv[i] = exp_sram[i];
    do_read(3, d);
    chk("R12 write committed", d, 8'h9B);
    power_down(0, "R10 dirty cleared by save");
    power_up("R2 restore length");
    do_read(3, d);
    chk("R12 word in saved image", d, 8'h9B);
  endtask

  task automatic t_abort;
    int n;
    power_down(0, "R5 clean sag");
    vrst_ok = 1'b1; vsw_ok = 1'b1;
    repeat (20) @(negedge clk);
    vrst_ok = 1'b0;
    @(negedge clk);
    chk("R8 busy during abort", int'(busy), 1);
    @(negedge clk);
    power_up("R8 restarted restore full length");
    check_all("R8 image after restart");
  endtask

  initial begin
    t_reset();
    t_first_recall();
    t_rw();
    t_sw_store();
    t_low_voltage();
    t_auto_store();
    t_busy_ignore();
    t_same_cycle();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule